// File: doc/BRIEF.md
# Per-Stream Coefficient Threshold Unit

This block sits between a multichannel wavelet engine and a zero-run encoder. Each coefficient it receives is in signed-magnitude form, with a sign bit at the top and the magnitude in the low bits. The coefficient carries a channel tag and a stream tag. Stream values 0 to LEVELS-1 are the detail levels, and stream LEVELS is the final approximation. The block keeps a separate threshold for every channel/stream pair. It sends on either the unchanged coefficient or a positive zero, so the encoder that follows sees long zero runs wherever the signal holds no energy.

Thresholds are written over a four-wire serial link (SPI mode 0, write only) into an internal table. Any entry may be rewritten while coefficients keep flowing. A monitor mode input makes the block pass every sample through untouched. An external host uses this mode to study raw channels before it chooses the thresholds.

Top module: `coef_thresh_unit`

## Requirements
- R1: After reset `out_valid` is low and every table entry is zero, so in acquisition mode every coefficient passes unchanged until a threshold is written.
- R2: In acquisition mode, a coefficient whose magnitude (bits DATA_W-2..0) is strictly below its entry's threshold leaves as all-zero bits (positive zero), whatever its sign.
- R3: In acquisition mode, a coefficient whose magnitude equals or exceeds its threshold leaves bit-for-bit unchanged, sign included. A negative zero meets a zero threshold and passes unchanged.
- R4: Output lags input by exactly one clock. `out_valid` copies the previous cycle's `in_valid`, and `out_ch`/`out_st` carry the tags of that same coefficient.
- R5: With `mode_monitor` high (1), every valid input leaves unchanged, whatever the thresholds and tags.
- R6: Entry index is channel*(LEVELS+1)+stream. Each entry is independent, so writing one leaves all the others as they were.
- R7: A write frame is framed by `spi_cs_n` low. MOSI is sampled on rising SCLK, and the frame is 8 address bits then 9 value bits, most significant bit first. The entry is updated once the 17th bit is taken.
- R8: A frame that ends (`spi_cs_n` high) with fewer than 17 bits writes nothing. Bits after the 17th are ignored, and the next frame starts afresh.
- R9: A frame whose address is CHANNELS*(LEVELS+1) or above changes no entry.
- R10: A rewrite during traffic is atomic. Each coefficient for that entry is judged against the complete old value or the complete new value, and once the frame has ended only the new value applies.
- R11: In acquisition mode, a coefficient whose stream tag is LEVELS+1 or above, or whose channel tag is CHANNELS or above, leaves as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_monitor | input | 1 | 1 = pass-through, 0 = thresholding |
| spi_sclk | input | 1 | Serial clock, idle low, at most clk/8 |
| spi_cs_n | input | 1 | Serial frame select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| in_valid | input | 1 | Coefficient present this cycle |
| in_data | input | DATA_W (10) | Signed-magnitude coefficient |
| in_ch | input | CH_W (5) | Channel tag |
| in_st | input | ST_W (3) | Stream tag (0..LEVELS-1 detail, LEVELS approximation) |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | DATA_W (10) | Coefficient or zero |
| out_ch | output | CH_W (5) | Channel tag of the result |
| out_st | output | ST_W (3) | Stream tag of the result |

## Verification
A corrupted table entry stays hidden until a coefficient for that exact channel/stream pair arrives with a magnitude between the true and the wrong threshold. It then shows one cycle later as a wrong zero or a wrong pass-through. For that reason the bench sweeps every entry at its threshold and one below it. A fault in the serial deserializer shows only after a frame has ended, as a change to the wrong entry or to no entry at all. A misaligned pipeline register shows at once, as tags or valid out of step with the data.

// File: rtl/coef_thresh_pkg.sv
package coef_thresh_pkg;

   typedef enum logic {
      MODE_ACQUIRE = 1'b0,
      MODE_MONITOR = 1'b1
   } path_mode_e;

   // serial frame length: address field followed by value field
   function automatic int frame_bits(input int addr_w, input int val_w);
      return addr_w + val_w;
   endfunction

   // flat table index of a channel/stream pair
   function automatic int table_index(input int ch, input int st, input int streams);
      return ch * streams + st;
   endfunction

endpackage

// File: rtl/cth_spi_rx.sv
module cth_spi_rx #(
   parameter int ADDR_W      = 8,
   parameter int THR_W       = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              cs_n,
   input  logic              mosi,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [THR_W-1:0]  wr_val
);
   localparam int FRAME_W = coef_thresh_pkg::frame_bits(ADDR_W, THR_W);
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cth_spi_rx: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sclk_q, cs_q, mosi_q;
   logic                   sclk_d;
   logic [CNT_W-1:0]       bit_cnt;
   logic [FRAME_W-2:0]     shreg;
   logic [FRAME_W-1:0]     frame_nx;
   logic                   sclk_rise, selected, bit_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q <= '0;
         cs_q   <= '1;
         mosi_q <= '0;
         sclk_d <= 1'b0;
      end else begin
         sclk_q <= {sclk_q[SYNC_STAGES-2:0], sclk};
         cs_q   <= {cs_q[SYNC_STAGES-2:0], cs_n};
         mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
         sclk_d <= sclk_q[SYNC_STAGES-1];
      end
   end

   assign sclk_rise = sclk_q[SYNC_STAGES-1] & ~sclk_d;
   assign selected  = ~cs_q[SYNC_STAGES-1];
   assign bit_in    = mosi_q[SYNC_STAGES-1];
   assign frame_nx  = {shreg, bit_in};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_val  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (!selected) begin
            bit_cnt <= '0;
         end else if (sclk_rise && (bit_cnt != CNT_W'(FRAME_W))) begin
            shreg   <= frame_nx[FRAME_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
               wr_en   <= 1'b1;
               wr_addr <= frame_nx[FRAME_W-1 -: ADDR_W];
               wr_val  <= frame_nx[THR_W-1:0];
            end
         end
      end
   end

endmodule

// File: rtl/cth_thr_bank.sv
module cth_thr_bank #(
   parameter int CHANNELS = 32,
   parameter int STREAMS  = 5,
   parameter int ADDR_W   = 8,
   parameter int THR_W    = 9,
   parameter int CH_W     = 5,
   parameter int ST_W     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [THR_W-1:0]  wr_val,
   input  logic [CH_W-1:0]   rd_ch,
   input  logic [ST_W-1:0]   rd_st,
   output logic              rd_ok,
   output logic [THR_W-1:0]  rd_thr
);
   localparam int ENTRIES = CHANNELS * STREAMS;
   localparam int IDX_W   = $clog2(ENTRIES);

   logic [THR_W-1:0]   thr [ENTRIES];
   logic [ENTRIES-1:0] hit;
   logic [IDX_W-1:0]   rd_idx;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_dec
      assign hit[e] = wr_en && (wr_addr == ADDR_W'(e));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) thr[e] <= '0;
      end else begin
         for (int e = 0; e < ENTRIES; e++)
            if (hit[e]) thr[e] <= wr_val;
      end
   end

   always_comb begin
      rd_ok  = (int'(rd_ch) < CHANNELS) && (int'(rd_st) < STREAMS);
      rd_idx = rd_ok ? IDX_W'(coef_thresh_pkg::table_index(int'(rd_ch), int'(rd_st), STREAMS))
                     : '0;
      rd_thr = rd_ok ? thr[rd_idx] : '0;
   end

endmodule

// File: rtl/cth_gate.sv
module cth_gate #(
   parameter int DATA_W = 10,
   parameter int THR_W  = 9,
   parameter int CH_W   = 5,
   parameter int ST_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [CH_W-1:0]   in_ch,
   input  logic [ST_W-1:0]   in_st,
   input  logic              thr_ok,
   input  logic [THR_W-1:0]  thr,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [CH_W-1:0]   out_ch,
   output logic [ST_W-1:0]   out_st
);
   import coef_thresh_pkg::*;

   localparam int MAG_W = DATA_W - 1;

   path_mode_e       mode_e;
   logic [MAG_W-1:0] mag;
   logic             keep;

   always_comb begin
      mode_e = path_mode_e'(mode);
      mag    = in_data[MAG_W-1:0];
      keep   = (mode_e == MODE_MONITOR) || (thr_ok && (mag >= thr));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_ch    <= '0;
         out_st    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= keep ? in_data : '0;
            out_ch   <= in_ch;
            out_st   <= in_st;
         end
      end
   end

endmodule

// File: rtl/coef_thresh_unit.sv
module coef_thresh_unit #(
   parameter int CHANNELS    = 32,
   parameter int LEVELS      = 4,
   parameter int DATA_W      = 10,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int CH_W        = $clog2(CHANNELS),
   parameter int ST_W        = $clog2(LEVELS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_monitor,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [CH_W-1:0]   in_ch,
   input  logic [ST_W-1:0]   in_st,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [CH_W-1:0]   out_ch,
   output logic [ST_W-1:0]   out_st
);
   localparam int STREAMS = LEVELS + 1;
   localparam int ENTRIES = CHANNELS * STREAMS;
   localparam int THR_W   = DATA_W - 1;

   if (ENTRIES > (1 << ADDR_W)) begin : g_bad_addr
      $error("coef_thresh_unit: ADDR_W too narrow for the table");
   end
   if (CH_W < $clog2(CHANNELS) || ST_W < $clog2(STREAMS)) begin : g_bad_tag
      $error("coef_thresh_unit: tag widths too narrow");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("coef_thresh_unit: DATA_W must hold sign and magnitude");
   end

   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr;
   logic [THR_W-1:0]  wr_val;
   logic              thr_ok;
   logic [THR_W-1:0]  thr;

   cth_spi_rx #(
      .ADDR_W(ADDR_W), .THR_W(THR_W), .SYNC_STAGES(SYNC_STAGES)
   ) u_spi (
      .clk(clk), .rst_n(rst_n),
      .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_val(wr_val)
   );

   cth_thr_bank #(
      .CHANNELS(CHANNELS), .STREAMS(STREAMS), .ADDR_W(ADDR_W),
      .THR_W(THR_W), .CH_W(CH_W), .ST_W(ST_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_val(wr_val),
      .rd_ch(in_ch), .rd_st(in_st), .rd_ok(thr_ok), .rd_thr(thr)
   );

   cth_gate #(
      .DATA_W(DATA_W), .THR_W(THR_W), .CH_W(CH_W), .ST_W(ST_W)
   ) u_gate (
      .clk(clk), .rst_n(rst_n), .mode(mode_monitor),
      .in_valid(in_valid), .in_data(in_data), .in_ch(in_ch), .in_st(in_st),
      .thr_ok(thr_ok), .thr(thr),
      .out_valid(out_valid), .out_data(out_data), .out_ch(out_ch), .out_st(out_st)
   );

endmodule

// File: rtl/coef_thresh_chk.sv
module coef_thresh_chk #(
   parameter int DATA_W   = 10,
   parameter int CH_W     = 5,
   parameter int ST_W     = 3,
   parameter int CHANNELS = 32,
   parameter int STREAMS  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_monitor,
   input logic              in_valid,
   input logic [DATA_W-1:0] in_data,
   input logic [CH_W-1:0]   in_ch,
   input logic [ST_W-1:0]   in_st,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic [CH_W-1:0]   out_ch,
   input logic [ST_W-1:0]   out_st
);

   assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_tags_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_ch == $past(in_ch) && out_st == $past(in_st)));

   assert_monitor_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mode_monitor) |=> (out_data == $past(in_data)));

   // R2 / R3: acquisition result is either the untouched coefficient or positive zero
   assert_zero_or_same_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mode_monitor) |=> (out_data == '0 || out_data == $past(in_data)));

   assert_bad_tag_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !mode_monitor &&
       (int'(in_st) >= STREAMS || int'(in_ch) >= CHANNELS)) |=> (out_data == '0));

endmodule

bind coef_thresh_unit coef_thresh_chk #(
   .DATA_W(DATA_W), .CH_W(CH_W), .ST_W(ST_W),
   .CHANNELS(CHANNELS), .STREAMS(LEVELS + 1)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_monitor(mode_monitor),
   .in_valid(in_valid), .in_data(in_data), .in_ch(in_ch), .in_st(in_st),
   .out_valid(out_valid), .out_data(out_data), .out_ch(out_ch), .out_st(out_st)
);

// File: tb/test_coef_thresh_unit.sv
`timescale 1ns/1ps
module test_coef_thresh_unit;
   localparam int NCH = 32;
   localparam int NST = 5;
   localparam int NE  = NCH * NST;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_monitor = 1'b0;
   logic       spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic       in_valid = 1'b0;
   logic [9:0] in_data = '0;
   logic [4:0] in_ch = '0;
   logic [2:0] in_st = '0;
   logic       out_valid;
   logic [9:0] out_data;
   logic [4:0] out_ch;
   logic [2:0] out_st;

   always #5 clk = ~clk;

   coef_thresh_unit i_coef_thresh_unit (
      .clk(clk), .rst_n(rst_n), .mode_monitor(mode_monitor),
      .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
      .in_valid(in_valid), .in_data(in_data), .in_ch(in_ch), .in_st(in_st),
      .out_valid(out_valid), .out_data(out_data), .out_ch(out_ch), .out_st(out_st)
   );

   int         n_chk = 0, n_bad = 0;
   int         thr_m [NE];
   logic       cur_mode = 1'b0;
   logic       e_valid = 1'b0, e_either = 1'b0;
   logic [9:0] e_data = '0;
   logic [4:0] e_ch = '0;
   logic [2:0] e_st = '0;
   string      e_tag = "R1";

   function automatic logic [9:0] mk(input int s, input int mag);
      return {1'(s), 9'(mag)};
   endfunction

   // reference: what a coefficient becomes, from the requirements
   function automatic logic [9:0] ref_out(input logic mon, input logic [9:0] d,
                                          input int ch, input int st);
      if (mon) return d;
      if (ch >= NCH || st >= NST) return '0;
      if (int'(d[8:0]) < thr_m[ch*NST + st]) return '0;
      return d;
   endfunction

   task automatic fail_line(input string tag, input string what, input int act, input int exp);
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
   endtask

   task automatic check_prev();
      n_chk++;
      if (out_valid !== e_valid) begin
         fail_line(e_tag, "out_valid", int'(out_valid), int'(e_valid));
      end else if (e_valid) begin
         if (!(out_data === e_data || (e_either && out_data === 10'b0)))
            fail_line(e_tag, "out_data", int'(out_data), int'(e_data));
         else if (out_ch !== e_ch || out_st !== e_st)
            fail_line(e_tag, "tags", int'({out_ch, out_st}), int'({e_ch, e_st}));
      end
   endtask

   // one cycle: check the previous result, then present a new input
   task automatic step(input logic v, input logic [9:0] d, input int ch, input int st,
                       input string tag, input logic either = 1'b0);
      @(negedge clk);
      check_prev();
      mode_monitor = cur_mode;
      in_valid = v;
      in_data  = d;
      in_ch    = 5'(ch);
      in_st    = 3'(st);
      e_valid  = v;
      e_data   = ref_out(cur_mode, d, ch, st);
      e_ch     = 5'(ch);
      e_st     = 3'(st);
      e_tag    = tag;
      e_either = either;
   endtask

   // R7: SPI mode 0 frame, address then value, MSB first
   task automatic spi_frame(input int addr, input int val, input int nbits);
      logic [16:0] f;
      f = {8'(addr), 9'(val)};
      spi_cs_n = 1'b0;
      #40;
      for (int i = 0; i < nbits; i++) begin
         spi_mosi = (i < 17) ? f[16-i] : 1'b1;
         #40 spi_sclk = 1'b1;
         #40 spi_sclk = 1'b0;
      end
      #40 spi_cs_n = 1'b1;
      spi_mosi = 1'b0;
      #100;
   endtask

   task automatic prog(input int addr, input int val);
      step(1'b0, '0, 0, 0, "R7");
      spi_frame(addr, val, 17);
      if (addr < NE) thr_m[addr] = val;
   endtask

   task automatic sweep(input string tag);
      for (int e = 0; e < NE; e++) begin
         step(1'b1, mk(e % 2, thr_m[e]), e / NST, e % NST, tag);
         if (thr_m[e] > 0) step(1'b1, mk(1 - e % 2, thr_m[e] - 1), e / NST, e % NST, tag);
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int e = 0; e < NE; e++) thr_m[e] = 0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0) fail_line("R1", "out_valid after reset", int'(out_valid), 0);

      // R1: empty table passes everything; R3: negative zero meets zero threshold
      step(1'b1, mk(0, 1), 0, 0, "R1");
      step(1'b1, mk(1, 0), 7, 4, "R3");
      step(1'b1, mk(1, 3), 31, 4, "R1");

      // R7 / R6: program several entries
      prog(17, 100);
      prog(18, 200);
      prog(159, 511);
      prog(0, 50);

      // R2 / R3 boundaries
      step(1'b1, mk(1, 99), 3, 2, "R2");
      step(1'b1, mk(0, 100), 3, 2, "R3");
      step(1'b1, mk(1, 101), 3, 2, "R3");
      step(1'b1, mk(0, 150), 3, 3, "R6");
      step(1'b1, mk(0, 150), 3, 2, "R6");
      step(1'b1, mk(1, 510), 31, 4, "R2");
      step(1'b1, mk(0, 511), 31, 4, "R3");
      step(1'b1, mk(1, 0), 0, 0, "R2");
      // R4: gaps
      step(1'b0, mk(0, 5), 1, 1, "R4");
      step(1'b1, mk(0, 5), 1, 1, "R4");
      step(1'b0, '0, 0, 0, "R4");

      // R5: monitor mode ignores thresholds and tags
      cur_mode = 1'b1;
      step(1'b1, mk(1, 99), 3, 2, "R5");
      step(1'b1, mk(0, 1), 0, 0, "R5");
      step(1'b1, mk(1, 7), 2, 6, "R5");
      cur_mode = 1'b0;

      // R11: bad stream tags
      for (int s = NST; s < 8; s++) step(1'b1, mk(0, 511), 4, s, "R11");

      // R9: out-of-range addresses change nothing
      prog(160, 7);
      prog(255, 9);
      sweep("R9");

      // R8: short frame discarded, long frame truncated, next frame clean
      step(1'b0, '0, 0, 0, "R8");
      spi_frame(5, 300, 10);
      spi_frame(6, 300, 20);
      thr_m[6] = 300;
      prog(7, 20);
      step(1'b1, mk(0, 1), 1, 0, "R8");
      step(1'b1, mk(0, 299), 1, 1, "R8");
      step(1'b1, mk(0, 300), 1, 1, "R8");
      step(1'b1, mk(0, 19), 1, 2, "R8");
      step(1'b1, mk(0, 20), 1, 2, "R8");

      // R10: rewrite entry 17 from 100 to 300 while it is being looked up
      fork
         spi_frame(17, 300, 17);
         for (int k = 0; k < 70; k++) begin
            step(1'b1, mk(k % 2, 200), 3, 2, "R10", 1'b1);
            step(1'b1, mk(0, 60), 0, 0, "R10");
         end
      join
      thr_m[17] = 300;
      step(1'b1, mk(0, 200), 3, 2, "R10");
      step(1'b1, mk(1, 300), 3, 2, "R10");

      // R6: full sweep of final table
      sweep("R6");
      step(1'b0, '0, 0, 0, "R4");
      step(1'b0, '0, 0, 0, "R4");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule